// File: doc/BRIEF.md
# Two-Bank Interrupt Source Register File

This block collects up to 64 interrupt inputs in two banks of 32 and places them behind a small word-addressed register bus. Edge-type inputs are caught in an event register on a rising transition. Level-type inputs are chosen per bank by a fixed mask. They are never latched, and they count as pending for as long as the input is held high. Software can enable sources, acknowledge caught edges and read the live state of every input. A single interrupt line goes high while any enabled source is pending.

Each bank has four word registers, in this order: event, enable, acknowledge and live level. Bank 0 serves sources 0 to 31 and bank 1 serves sources 32 to 63. An edge that is already high when its enable bit is set produces no event. Software that needs the current state reads the live level register.

The bus is plain: a request is one cycle with select, write, address and data. Read data comes back on the following cycle, qualified by a valid strobe. The bus has no back-pressure, so every request is accepted in the cycle it is presented.

Top module: `irqc_regfile`

## Requirements
- R1: After reset, every enable and event bit is 0, `irq_o` is low, `bus_rvalid` is low and `bus_rdata` is 0.
- R2: Word offsets within the 64-byte window are: bank 1 at 0x10/0x14/0x18/0x1C and bank 0 at 0x20/0x24/0x28/0x2C, holding event, enable, acknowledge and level in that order. Bit n of a bank 0 register is source n and bit n of a bank 1 register is source 32+n. Data is little-endian, with byte 0 in bits 7:0 and no lane swap.
- R3: The enable register reads back exactly the last value written. Writing 0 to it masks every source of that bank, so `irq_o` falls two cycles after the write.
- R4: An edge-type source sets its event bit on a 0-to-1 input transition, but only if its enable bit is already 1. A transition seen while the bit is 0 leaves the event bit clear.
- R5: Setting an enable bit while its edge-type input is already high sets no event bit, and `irq_o` stays low.
- R6: A 1 written to an acknowledge bit clears the matching event bit, and 0 bits leave event bits unchanged. The acknowledge register reads 0.
- R7: If a set and an acknowledge of the same event bit fall in the same cycle, the bit ends up set.
- R8: The level register returns the present state of every input of its bank, whatever the enable bits hold.
- R9: The level-type mask is 0x1FF00000 for bank 0 (sources 20 to 28) and 0 for bank 1. A level-type source never sets its event bit. While its input is high and it is enabled, it is pending.
- R10: `irq_o` is a register holding the OR over both banks of (event OR (input AND level mask)) AND enable. It follows a level input one cycle later and a caught edge two cycles later.
- R11: Writes to event and level registers are ignored. Offsets outside the eight mapped words, or with address bits 1:0 not zero, read 0 and ignore writes.
- R12: A read request returns data and `bus_rvalid`=1 on the next cycle. In every other cycle `bus_rvalid`=0 and `bus_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address in the 64-byte window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| src_i | input | 64 | Interrupt inputs, synchronous to clk |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench changes inputs just after a falling edge and samples just after the next falling edge. A result due N rising edges after a stimulus is therefore observed N falling edges later. Read data is due one edge after the request. Register writes take effect on the edge that accepts them. A level input reaches `irq_o` after one edge, while a caught edge needs two: one to set the event bit and one for the output register. The bench also samples `irq_o` at one edge after an edge-type input rises, to confirm the line is still low at that point. Expected read words go into a queue in request order, and a falling-edge monitor pops one entry each time `bus_rvalid` is seen.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned ADDR_W   = 6;
  localparam int unsigned NUM_BANK = 2;

  typedef enum logic [1:0] {
    REG_EVENT = 2'd0,
    REG_ENABLE = 2'd1,
    REG_ACK   = 2'd2,
    REG_LEVEL = 2'd3
  } reg_sel_e;

  // Word-index bits [5:4] of each bank's base: bank 0 at 0x20, bank 1 at 0x10.
  function automatic logic [1:0] bank_base(input int unsigned b);
    return (b == 0) ? 2'b10 : 2'b01;
  endfunction
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int unsigned NBANK = NUM_BANK
) (
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NBANK-1:0]  hit_o,
  output reg_sel_e          reg_o,
  output logic [NBANK-1:0]  en_we_o,
  output logic [NBANK-1:0]  ack_we_o,
  output logic              rd_o
);
  logic aligned;
  assign aligned = (addr_i[1:0] == 2'b00);
  assign reg_o   = reg_sel_e'(addr_i[3:2]);
  assign rd_o    = sel_i & ~wr_i;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign hit_o[b]    = aligned && (addr_i[5:4] == bank_base(b));
    assign en_we_o[b]  = sel_i & wr_i & hit_o[b] & (reg_o == REG_ENABLE);
    assign ack_we_o[b] = sel_i & wr_i & hit_o[b] & (reg_o == REG_ACK);
  end
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
  import irqc_pkg::*;
#(
  parameter int unsigned      W          = WORD_W,
  parameter logic [WORD_W-1:0] LEVEL_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  input  logic         en_we_i,
  input  logic         ack_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] event_o,
  output logic [W-1:0] enable_o,
  output logic [W-1:0] level_o,
  output logic         pend_o
);
  localparam logic [W-1:0] LVL  = LEVEL_MASK[W-1:0];
  localparam logic [W-1:0] EDGE = ~LVL;

  logic [W-1:0] src_q, event_q, en_q;
  logic [W-1:0] rise, set_vec, clr_vec, pending;

  assign rise    = src_i & ~src_q;
  assign set_vec = rise & en_q & EDGE;
  assign clr_vec = ack_we_i ? wdata_i : '0;
  assign pending = (event_q | (src_i & LVL)) & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      event_q <= '0;
      en_q    <= '0;
    end else begin
      src_q   <= src_i;
      event_q <= (event_q & ~clr_vec) | set_vec;
      if (en_we_i) en_q <= wdata_i;
    end
  end

  assign event_o  = event_q;
  assign enable_o = en_q;
  assign level_o  = src_i;
  assign pend_o   = |pending;

  AST_EVENT_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((event_q & ~$past(event_q) & ~$past(rise & en_q)) == '0)); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we_i && (rise == '0)) |=> ((event_q & $past(wdata_i)) == '0)); // R6
  AST_EN_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    en_we_i |=> (enable_o == $past(wdata_i))); // R3
  AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ((event_q & LVL) == '0)); // R9
endmodule

// File: rtl/irqc_regfile.sv
module irqc_regfile
  import irqc_pkg::*;
#(
  parameter logic [WORD_W-1:0] BANK0_LEVEL = 32'h1FF0_0000,
  parameter logic [WORD_W-1:0] BANK1_LEVEL = 32'h0000_0000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_sel,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [WORD_W-1:0]          bus_wdata,
  output logic [WORD_W-1:0]          bus_rdata,
  output logic                       bus_rvalid,
  input  logic [NUM_BANK*WORD_W-1:0] src_i,
  output logic                       irq_o
);
  localparam int unsigned NSRC = NUM_BANK * WORD_W;

  logic [NUM_BANK-1:0] hit, en_we, ack_we, pend;
  reg_sel_e            rsel;
  logic                rd;
  logic [WORD_W-1:0]   ev   [NUM_BANK];
  logic [WORD_W-1:0]   en   [NUM_BANK];
  logic [WORD_W-1:0]   lv   [NUM_BANK];
  logic [NSRC-1:0]     en_flat;
  logic [WORD_W-1:0]   rd_mux;
  logic                irq_q, rvalid_q;
  logic [WORD_W-1:0]   rdata_q;

  irqc_decode #(.NBANK(NUM_BANK)) u_dec (
    .sel_i(bus_sel), .wr_i(bus_wr), .addr_i(bus_addr),
    .hit_o(hit), .reg_o(rsel), .en_we_o(en_we), .ack_we_o(ack_we), .rd_o(rd)
  );

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    localparam logic [WORD_W-1:0] MASK = (b == 0) ? BANK0_LEVEL : BANK1_LEVEL;
    irqc_bank #(.W(WORD_W), .LEVEL_MASK(MASK)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .src_i(src_i[b*WORD_W +: WORD_W]),
      .en_we_i(en_we[b]), .ack_we_i(ack_we[b]), .wdata_i(bus_wdata),
      .event_o(ev[b]), .enable_o(en[b]), .level_o(lv[b]), .pend_o(pend[b])
    );
    assign en_flat[b*WORD_W +: WORD_W] = en[b];
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANK; b++) begin
      if (hit[b]) begin
        unique case (rsel)
          REG_EVENT:  rd_mux = ev[b];
          REG_ENABLE: rd_mux = en[b];
          REG_ACK:    rd_mux = '0;
          REG_LEVEL:  rd_mux = lv[b];
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q    <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      irq_q    <= |pend;
      rvalid_q <= rd;
      rdata_q  <= rd ? rd_mux : '0;
    end
  end

  assign irq_o      = irq_q;
  assign bus_rvalid = rvalid_q;
  assign bus_rdata  = rdata_q;

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($past(en_flat) != '0)); // R10
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rvalid |-> (bus_rdata == '0)); // R12
  AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> bus_rvalid); // R12
endmodule

// File: tb/sim_irqc_regfile.sv
module sim_irqc_regfile;
  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        bus_rvalid, irq_o;
  logic [63:0] src = '0;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  irqc_regfile u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .src_i(src), .irq_o(irq_o)
  );

  task automatic report();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      report();
    end
  end

  // Monitor: pops expected read words when data comes back.
  always @(negedge clk) if (rst_n) begin
    if (bus_rvalid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++; $display("FAIL R12 unexpected rvalid: actual=%h expected=none", bus_rdata);
      end else begin
        logic [31:0] e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          n_bad++; $display("FAIL %s read: actual=%h expected=%h", t, bus_rdata, e);
        end
      end
    end else if (bus_rdata !== 32'h0) begin
      n_chk++; n_bad++;
      $display("FAIL R12 idle rdata: actual=%h expected=0", bus_rdata);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [5:0] a, logic [31:0] e, string t);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic chk_irq(logic e, string t);
    n_chk++;
    if (irq_o !== e) begin
      n_bad++; $display("FAIL %s irq: actual=%b expected=%b", t, irq_o, e);
    end
  endtask

  initial begin
    idle(3);
    chk_irq(0, "R1");
    n_chk++;
    if (bus_rvalid !== 0) begin n_bad++; $display("FAIL R1 rvalid: actual=%b expected=0", bus_rvalid); end
    rst_n = 1;
    idle(1);
    rd(6'h24, 0, "R1"); rd(6'h14, 0, "R1"); rd(6'h20, 0, "R1"); rd(6'h10, 0, "R1");
    // R2/R3 enable readback in both banks
    wr(6'h24, 32'h1);          rd(6'h24, 32'h1, "R3");
    wr(6'h14, 32'hA5A5_0003);  rd(6'h14, 32'hA5A5_0003, "R2");
    // R4 edge catch on source 0, R10 two-cycle latency
    src[0] = 1;
    idle(1); chk_irq(0, "R10");
    idle(1); chk_irq(1, "R4");
    rd(6'h20, 32'h1, "R4");
    // R6 ack with zero bit 0 has no effect; then real ack
    wr(6'h28, 32'hFFFF_FFFE); rd(6'h20, 32'h1, "R6");
    wr(6'h28, 32'h1); idle(1); chk_irq(0, "R6");
    rd(6'h20, 0, "R6"); rd(6'h28, 0, "R6");
    // R4 rise while disabled
    src[1] = 1; idle(2); rd(6'h20, 0, "R4");
    // R5 enable an already high edge source
    src[2] = 1; idle(1);
    wr(6'h24, 32'h5); idle(2); chk_irq(0, "R5"); rd(6'h20, 0, "R5");
    // R7 set and ack in the same cycle
    wr(6'h24, 32'hD);
    src[3] = 1; wr(6'h28, 32'h8);
    rd(6'h20, 32'h8, "R7"); chk_irq(1, "R7");
    // R3 mask by writing 0
    wr(6'h24, 0); idle(1); chk_irq(0, "R3"); rd(6'h24, 0, "R3");
    wr(6'h28, 32'h8); rd(6'h20, 0, "R6");
    // R8 live levels regardless of enable
    rd(6'h2C, 32'hF, "R8"); rd(6'h1C, 0, "R8");
    // R2 bank 1 maps source 33 to bit 1
    src[33] = 1; idle(2); chk_irq(1, "R2");
    rd(6'h10, 32'h2, "R2");
    wr(6'h18, 32'h2); idle(1); chk_irq(0, "R6");
    rd(6'h1C, 32'h2, "R8");
    // R9 level source 20
    wr(6'h24, 32'h0010_0000); idle(1);
    src[20] = 1; idle(1); chk_irq(1, "R9");
    rd(6'h20, 0, "R9"); rd(6'h2C, 32'h0010_000F, "R8");
    src[20] = 0; idle(1); chk_irq(0, "R9");
    // R11 ignored writes and unmapped offsets
    wr(6'h20, 32'hFFFF_FFFF); rd(6'h20, 0, "R11");
    wr(6'h2C, 32'h0);         rd(6'h2C, 32'hF, "R11");
    rd(6'h00, 0, "R11"); wr(6'h04, 32'hFFFF_FFFF); rd(6'h3C, 0, "R11");
    wr(6'h25, 32'hFFFF_FFFF); rd(6'h25, 0, "R11");
    rd(6'h24, 32'h0010_0000, "R11");
    idle(3);
    chk_irq(0, "R11");
    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++; $display("FAIL R12 missing reads: actual=%0d expected=0", exp_q.size());
    end
    report();
  end
endmodule